// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt request lines from several devices and presents a single request with a vector to the processor. Each ordinary line has a fixed priority equal to its index, and the highest line is the most urgent. A separate non-maskable line outranks all of them. A rising edge on a line marks that line as pending. The pending mark stays until the processor takes that interrupt.

The controller keeps a stack of the priority levels being serviced. A line is offered only when its level is strictly above the level on top of the stack. Lines that are blocked stay pending and are offered again once a return from service lowers the level. The processor takes an interrupt by pulsing the acknowledge input at an instruction boundary. On that cycle the vector on the output selects the service routine, and its level is pushed onto the stack. A return pulse pops the stack and restores the previous level. The non-maskable line is offered in every case except a full stack, and it is encoded as one past the highest line index.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, `svc_valid` is 0, and the stack is empty.
- R2: A line becomes pending on a 0-to-1 transition. A line held at 1 after it has been acknowledged does not raise a new request.
- R3: While the stack is not empty, an ordinary line is offered only if its index is strictly greater than `svc_level`. A blocked line stays pending and is offered after returns lower the level.
- R4: Among the eligible lines, `vec_out` carries the highest index. `irq_out` is 1 whenever any line is eligible.
- R5: A pending non-maskable request is offered with vector 8 (binary 1000). It outranks every ordinary line, and no in-service level blocks it, including level 8 itself.
- R6: When `inta` is 1 while `irq_out` is 1, the offered level is pushed: on the next cycle `svc_valid` is 1 and `svc_level` equals that vector, and the request's pending mark is cleared. When `inta` is 1 while `irq_out` is 0, it has no effect.
- R7: An `iret` pulse pops one level and restores the previous `svc_level`. When the stack becomes empty, `svc_valid` drops to 0. An `iret` on an empty stack has no effect.
- R8: If `inta` and `iret` are 1 in the same cycle, only the return takes effect, and the offered request stays pending.
- R9: While 8 levels are stacked, `irq_out` is 0, even for a non-maskable request. Such a request is offered again after one return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Device request lines; the index is the priority |
| nmi_line | input | 1 | Non-maskable request line |
| inta | input | 1 | Instruction-boundary acknowledge |
| iret | input | 1 | Return-from-service pulse |
| irq_out | output | 1 | A request is offered to the processor |
| vec_out | output | 4 | Vector of the offered request (8 = non-maskable) |
| svc_valid | output | 1 | At least one level is in service |
| svc_level | output | 4 | Level on top of the stack (0 when empty) |

## Verification
Every ordered pair of lines is swept: one line is taken into service, then the second line is raised. This separates a higher line, which must preempt, from an equal or lower line, which must wait and then appear after the return. Raising all eight lines at once and then stepping through take-and-return cycles checks the descending priority order. Separate sequences cover nested non-maskable requests, a stack filled to its depth, a line held high, and acknowledge or return pulses that arrive with nothing to act on or in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int DEF_LINES = 8;
  localparam int DEF_DEPTH = 8;

  // Width needed to encode every line index plus the non-maskable code.
  function automatic int vec_width(input int lines);
    return $clog2(lines + 1);
  endfunction

  // Index of the most significant set bit (0 when none is set).
  function automatic int unsigned top_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int k = 0; k < 32; k++) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  assign rise = lines & ~prev_q;
  assign pend = pend_q;

  // Each latch: a new edge sets it (set wins over a same-cycle clear).
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= lines[i];
        if (rise[i])     pend_q[i] <= 1'b1;
        else if (clr[i]) pend_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] top_lvl,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] depth
);

  logic [LW-1:0] slot_q [DEPTH];
  logic [CW-1:0] cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign depth   = cnt_q;
  assign top_lvl = empty ? '0 : slot_q[PW'(cnt_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (push && !full) begin
      slot_q[PW'(cnt_q)] <= push_lvl;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 8,
  parameter int LW = 4
) (
  input  logic [N-1:0]  pend,
  input  logic          nmi_pend,
  input  logic          stk_empty,
  input  logic          stk_full,
  input  logic [LW-1:0] top_lvl,
  output logic          req,
  output logic [LW-1:0] vec,
  output logic [N-1:0]  grant_line,
  output logic          grant_nmi
);
  import irq_pkg::*;

  logic [N-1:0]  elig;
  logic [LW-1:0] best;

  // A line is eligible when pending and above the in-service level.
  for (genvar i = 0; i < N; i++) begin : g_elig
    assign elig[i] = pend[i] && (stk_empty || (LW'(i) > top_lvl));
  end

  assign best      = LW'(top_index(32'(elig)));
  assign grant_nmi = nmi_pend && !stk_full;
  assign req       = !stk_full && (nmi_pend || (|elig));
  assign vec       = nmi_pend ? LW'(N) : best;

  for (genvar i = 0; i < N; i++) begin : g_grant
    assign grant_line[i] = req && !nmi_pend && elig[i] && (best == LW'(i));
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES   = irq_pkg::DEF_LINES,
  parameter int STACK_DEPTH = irq_pkg::DEF_DEPTH,
  localparam int VW = irq_pkg::vec_width(NUM_LINES),
  localparam int CW = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 nmi_line,
  input  logic                 inta,
  input  logic                 iret,
  output logic                 irq_out,
  output logic [VW-1:0]        vec_out,
  output logic                 svc_valid,
  output logic [VW-1:0]        svc_level
);

  logic [NUM_LINES-1:0] line_pend, line_rise, line_clr, grant_line;
  logic [0:0]           nmi_pend_v, nmi_rise_v, nmi_clr_v;
  logic                 nmi_pend, grant_nmi;
  logic                 stk_empty, stk_full;
  logic [VW-1:0]        top_lvl;
  logic [CW-1:0]        stk_depth;

  // Named events observed by the checker.
  logic take_evt, pop_evt;

  assign take_evt = inta && irq_out && !iret;
  assign pop_evt  = iret && !stk_empty;

  assign line_clr     = take_evt ? grant_line : '0;
  assign nmi_clr_v[0] = take_evt && grant_nmi;
  assign nmi_pend     = nmi_pend_v[0];

  irq_edge_latch #(.N(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .clr(line_clr),
    .pend(line_pend), .rise(line_rise)
  );

  irq_edge_latch #(.N(1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .lines(nmi_line), .clr(nmi_clr_v),
    .pend(nmi_pend_v), .rise(nmi_rise_v)
  );

  irq_arbiter #(.N(NUM_LINES), .LW(VW)) u_arb (
    .pend(line_pend), .nmi_pend(nmi_pend), .stk_empty(stk_empty),
    .stk_full(stk_full), .top_lvl(top_lvl), .req(irq_out), .vec(vec_out),
    .grant_line(grant_line), .grant_nmi(grant_nmi)
  );

  irq_level_stack #(.DEPTH(STACK_DEPTH), .LW(VW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take_evt), .push_lvl(vec_out),
    .pop(pop_evt), .top_lvl(top_lvl), .empty(stk_empty), .full(stk_full),
    .depth(stk_depth)
  );

  assign svc_valid = !stk_empty;
  assign svc_level = top_lvl;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_LINES = 8,
  parameter int VW = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inta,
  input logic          iret,
  input logic          irq_out,
  input logic [VW-1:0] vec_out,
  input logic          svc_valid,
  input logic [VW-1:0] svc_level,
  input logic [CW-1:0] stk_depth,
  input logic          take_evt,
  input logic          pop_evt,
  input logic          nmi_pend,
  input logic          stk_full
);

  a_r6_push_level: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (svc_valid && svc_level == $past(vec_out)))
    else $error("R6 pushed level mismatch");

  a_r6_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !irq_out && !iret) |=> (stk_depth == $past(stk_depth)))
    else $error("R6 idle acknowledge changed depth");

  a_r7_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (stk_depth == $past(stk_depth) - 1'b1))
    else $error("R7 pop depth");

  a_r8_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && iret) |=> (stk_depth <= $past(stk_depth)))
    else $error("R8 push during return");

  a_r3_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && svc_valid && vec_out != VW'(NUM_LINES)) |-> (vec_out > svc_level))
    else $error("R3 masked line offered");

  a_r5_nmi_offered: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !stk_full) |-> (irq_out && vec_out == VW'(NUM_LINES)))
    else $error("R5 non-maskable not offered");

  a_r9_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_out)
    else $error("R9 request while full");

endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_LINES(NUM_LINES), .VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .iret(iret), .irq_out(irq_out),
  .vec_out(vec_out), .svc_valid(svc_valid), .svc_level(svc_level),
  .stk_depth(stk_depth), .take_evt(take_evt), .pop_evt(pop_evt),
  .nmi_pend(nmi_pend), .stk_full(stk_full)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       nmi_line = 1'b0;
  logic       inta = 1'b0;
  logic       iret = 1'b0;
  logic       irq_out, svc_valid;
  logic [3:0] vec_out, svc_level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_line(nmi_line),
    .inta(inta), .iret(iret), .irq_out(irq_out), .vec_out(vec_out),
    .svc_valid(svc_valid), .svc_level(svc_level)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expect an offered request with vector v, or none when v < 0.
  task automatic chk_req(input int v, input string rq);
    total++;
    if (v < 0) begin
      if (irq_out !== 1'b0) begin
        bad++;
        $display("FAIL %s: irq_out=%0b vec=%0d expected irq_out=0", rq, irq_out, vec_out);
      end
    end else if (irq_out !== 1'b1 || vec_out !== 4'(v)) begin
      bad++;
      $display("FAIL %s: irq_out=%0b vec=%0d expected irq_out=1 vec=%0d", rq, irq_out, vec_out, v);
    end
  endtask

  // Expect in-service level l, or empty when l < 0.
  task automatic chk_lvl(input int l, input string rq);
    total++;
    if (l < 0) begin
      if (svc_valid !== 1'b0) begin
        bad++;
        $display("FAIL %s: svc_valid=%0b level=%0d expected empty", rq, svc_valid, svc_level);
      end
    end else if (svc_valid !== 1'b1 || svc_level !== 4'(l)) begin
      bad++;
      $display("FAIL %s: svc_valid=%0b level=%0d expected level=%0d", rq, svc_valid, svc_level, l);
    end
  endtask

  task automatic pulse_line(input int i);
    irq_lines[i] = 1'b1; tick(); irq_lines[i] = 1'b0;
  endtask
  task automatic pulse_nmi();
    nmi_line = 1'b1; tick(); nmi_line = 1'b0;
  endtask
  task automatic ack();
    inta = 1'b1; tick(); inta = 1'b0;
  endtask
  task automatic ret();
    iret = 1'b1; tick(); iret = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk_req(-1, "R1 reset request");
    chk_lvl(-1, "R1 reset level");

    // R6: acknowledge with nothing offered; R7: return on empty stack
    ack();
    chk_lvl(-1, "R6 idle acknowledge");
    ret();
    chk_lvl(-1, "R7 return on empty");
    pulse_line(2); ack();
    chk_lvl(2, "R7 stack intact after empty return");
    ret();

    // Pair sweep: a in service, then b raised (R3, R4, R6, R7)
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        pulse_line(a);
        chk_req(a, "R4 single line");
        ack();
        chk_lvl(a, "R6 push");
        chk_req(-1, "R2 pending cleared");
        pulse_line(b);
        if (b > a) begin
          chk_req(b, "R3 higher preempts");
          ack();
          chk_lvl(b, "R6 nested push");
          ret();
          chk_lvl(a, "R7 restore previous");
          chk_req(-1, "R3 nothing left");
          ret();
        end else begin
          chk_req(-1, "R3 blocked at or below");
          ret();
          chk_lvl(-1, "R7 empty after return");
          chk_req(b, "R3 blocked line delivered");
          ack(); ret();
        end
        chk_req(-1, "R2 idle after pair");
        chk_lvl(-1, "R7 idle after pair");
      end
    end

    // R4: all lines at once, served in descending order
    irq_lines = 8'hFF; tick(); irq_lines = '0;
    for (int d = 7; d >= 0; d--) begin
      chk_req(d, "R4 descending order");
      ack();
      chk_req(-1, "R3 rest blocked");
      ret();
    end

    // R2: held line does not retrigger
    irq_lines[3] = 1'b1; tick();
    ack(); ret();
    tick();
    chk_req(-1, "R2 held line no retrigger");
    irq_lines[3] = 1'b0; tick();

    // R8: acknowledge and return together
    pulse_line(5); ack();
    pulse_line(6);
    chk_req(6, "R8 setup");
    inta = 1'b1; iret = 1'b1; tick(); inta = 1'b0; iret = 1'b0;
    chk_lvl(-1, "R8 return took effect");
    chk_req(6, "R8 request kept");
    ack(); ret();

    // R5: nested non-maskable requests
    pulse_line(7); ack();
    pulse_nmi();
    chk_req(8, "R5 outranks level 7");
    ack();
    chk_lvl(8, "R5 nmi in service");
    pulse_nmi();
    chk_req(8, "R5 nmi within nmi");
    ack();
    pulse_line(6);
    chk_req(-1, "R3 blocked under nmi");
    ret();
    chk_lvl(8, "R7 restore nmi level");
    ret();
    chk_lvl(7, "R7 restore level 7");
    ret();
    chk_req(6, "R3 delivered after nmi");
    ack(); ret();

    // R9: full stack
    for (int i = 0; i < 8; i++) begin
      pulse_line(i); ack();
    end
    chk_lvl(7, "R9 stack full at 7");
    pulse_nmi();
    chk_req(-1, "R9 full blocks nmi");
    ret();
    chk_req(8, "R9 nmi after one return");
    ack();
    chk_lvl(8, "R9 nmi pushed");
    for (int i = 0; i < 8; i++) ret();
    chk_lvl(-1, "R7 fully unwound");
    chk_req(-1, "R9 idle at end");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule